// File: doc/BRIEF.md
# Inter-Core Doorbell Mailbox Unit

This unit gives every core in a cluster one 32-bit doorbell word and one interrupt line. A core rings a doorbell on another core (or on itself) by writing a mask to the target's post register. Every 1 in that mask is ORed into the target word, so writing `1 << n` raises message `n`. The target core reads its word back through its acknowledge register. It then retires any chosen subset of bits by writing them as 1 to the same address. A typical handler acknowledges only the lowest pending bit.

Each core has its own register port into the unit, so several cores can post and acknowledge in the same clock cycle. The mailbox interrupt of a core is a level. It is high while that core's doorbell word is nonzero and its interrupt enable bit is set. All state is held in flops, and every change becomes visible in the cycle after the write.

Register windows (byte addresses, with parameterised bases): enable registers at `ENA_BASE + 4*N`, post registers at `SET_BASE + 16*N`, and acknowledge registers at `CLR_BASE + 16*N`. The defaults are 0x00, 0x40 and 0x80.

Top module: `mbx_doorbell_unit`

## Requirements
- R1: After reset all doorbell words and enables are zero, every interrupt output is low and every read-data output is zero.
- R2: A write of value V from any port to `SET_BASE + 16*N` makes core N's word `old | V`. The words of other cores do not change.
- R3: A write of value V to `CLR_BASE + 16*N` makes core N's word `old & ~V`, so only the bits written as 1 are cleared. Writing 0 changes nothing.
- R4: A read (`bus_en=1`, `bus_wr=0`) of `CLR_BASE + 16*N` returns core N's word on that port's `bus_rdata` in the next cycle. A read of `ENA_BASE + 4*N` returns the enable in bit 0, with zeros above it. `bus_rdata` holds its value while the port is not reading.
- R5: A write to `ENA_BASE + 4*N` stores bit 0 of the write data as core N's enable. Bits 31..1 are ignored.
- R6: `mbox_irq[N]` is 1 exactly when core N's enable is 1 and its word is nonzero. A write that changes either one shows on the output in the cycle after the write, including the fall after the last bit is acknowledged.
- R7: When a post and an acknowledge reach the same word in one cycle, the clear is applied first and then the set. A bit that is both cleared and posted therefore ends up set.
- R8: Posts from several ports to the same word in one cycle are all ORed in. When several ports write the same enable in one cycle, the lowest-numbered port wins.
- R9: Writes to addresses that are unmapped or not aligned to the register stride change no state. Reads of a post register and of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | NUM_CORES | Per-port access strobe |
| bus_wr | input | NUM_CORES | Per-port write (1) or read (0) |
| bus_addr | input | NUM_CORES*ADDR_W | Per-port byte address, port p in slice p |
| bus_wdata | input | NUM_CORES*DATA_W | Per-port write data |
| bus_rdata | output | NUM_CORES*DATA_W | Per-port read data, registered |
| mbox_irq | output | NUM_CORES | Per-core mailbox interrupt level |

## Verification
On every cycle, assertions in the slot and read-port logic check four properties:
- posted bits appear in the word;
- acknowledged bits that were not also posted disappear;
- bits that no write touched keep their value;
- the interrupt only rises after a post or an enable and only falls after an acknowledge or a disable. They also check that read data holds between reads and that post registers read as zero.

Some behaviour can only be shown by the bench's scenarios:
- the address decode: strides, misaligned and unmapped addresses;
- the exact word values after posting and acknowledging each of the 32 bits on each core;
- the order of a same-cycle clear and set;
- the OR of concurrent posts;
- the one-cycle timing of the interrupt.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    // Kind of register a port access resolves to.
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_ENA  = 2'd1,
        REG_SET  = 2'd2,
        REG_CLR  = 2'd3
    } reg_kind_e;

    localparam int ENA_STRIDE = 4;
    localparam int MBX_STRIDE = 16;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int              NUM_CORES = 4,
    parameter int              ADDR_W    = 8,
    parameter int              CORE_W    = 2,
    parameter logic [ADDR_W-1:0] ENA_BASE = 'h00,
    parameter logic [ADDR_W-1:0] SET_BASE = 'h40,
    parameter logic [ADDR_W-1:0] CLR_BASE = 'h80
) (
    input  logic                 bus_en,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_CORES-1:0] set_sel,
    output logic [NUM_CORES-1:0] clr_sel,
    output logic [NUM_CORES-1:0] ena_sel,
    output logic                 rd_en,
    output reg_kind_e            rd_kind,
    output logic [CORE_W-1:0]    rd_core
);

    localparam logic [ADDR_W-1:0] ENA_SPAN = ADDR_W'(NUM_CORES * ENA_STRIDE);
    localparam logic [ADDR_W-1:0] MBX_SPAN = ADDR_W'(NUM_CORES * MBX_STRIDE);

    logic [ADDR_W-1:0] off_ena_d, off_set_d, off_clr_d;
    logic [ADDR_W-1:0] idx_d;
    reg_kind_e         kind_d;
    logic [NUM_CORES-1:0] onehot_d;

    always_comb begin
        // Unsigned wrap makes an address below a base land outside its span.
        off_ena_d = bus_addr - ENA_BASE;
        off_set_d = bus_addr - SET_BASE;
        off_clr_d = bus_addr - CLR_BASE;

        kind_d = REG_NONE;
        idx_d  = '0;
        if ((off_ena_d < ENA_SPAN) && (off_ena_d[1:0] == 2'b00)) begin
            kind_d = REG_ENA;
            idx_d  = off_ena_d >> 2;
        end else if ((off_set_d < MBX_SPAN) && (off_set_d[3:0] == 4'h0)) begin
            kind_d = REG_SET;
            idx_d  = off_set_d >> 4;
        end else if ((off_clr_d < MBX_SPAN) && (off_clr_d[3:0] == 4'h0)) begin
            kind_d = REG_CLR;
            idx_d  = off_clr_d >> 4;
        end

        onehot_d = NUM_CORES'(1) << idx_d;

        set_sel = '0;
        clr_sel = '0;
        ena_sel = '0;
        if (bus_en && bus_wr) begin
            case (kind_d)
                REG_SET: set_sel = onehot_d;
                REG_CLR: clr_sel = onehot_d;
                REG_ENA: ena_sel = onehot_d;
                default: ;
            endcase
        end

        rd_en   = bus_en && !bus_wr;
        rd_kind = rd_en ? kind_d : REG_NONE;
        rd_core = CORE_W'(idx_d);
    end

endmodule

// File: rtl/mbx_core_slot.sv
module mbx_core_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_mask,
    input  logic [DATA_W-1:0] clr_mask,
    input  logic              ena_we,
    input  logic              ena_wbit,
    output logic [DATA_W-1:0] mbox_o,
    output logic              ena_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [DATA_W-1:0] mbox;
        logic              ena;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d      = slot_q;
        // Clear first, then set: a bit posted in the same cycle survives.
        slot_d.mbox = (slot_q.mbox & ~clr_mask) | set_mask;
        if (ena_we) begin
            slot_d.ena = ena_wbit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign mbox_o = slot_q.mbox;
    assign ena_o  = slot_q.ena;
    assign irq_o  = slot_q.ena & (|slot_q.mbox);

    AST_SET_POSTS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((mbox_o & $past(set_mask)) == $past(set_mask))); // R2

    AST_CLR_ACKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~set_mask) != '0) |=> ((mbox_o & $past(clr_mask & ~set_mask)) == '0)); // R7

    AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (((mbox_o ^ $past(mbox_o)) & ~$past(set_mask | clr_mask)) == '0)); // R3

    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((set_mask != '0) || (ena_we && ena_wbit))); // R6

    AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past((clr_mask != '0) || (ena_we && !ena_wbit))); // R6

endmodule

// File: rtl/mbx_read_port.sv
module mbx_read_port
    import mbx_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    parameter int CORE_W    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rd_en,
    input  reg_kind_e                     rd_kind,
    input  logic [CORE_W-1:0]             rd_core,
    input  logic [NUM_CORES*DATA_W-1:0]   mbox_all,
    input  logic [NUM_CORES-1:0]          ena_all,
    output logic [DATA_W-1:0]             rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.rdata = '0;
            case (rd_kind)
                REG_CLR: rd_d.rdata = mbox_all[rd_core*DATA_W +: DATA_W];
                REG_ENA: rd_d.rdata = DATA_W'(ena_all[rd_core]);
                default: rd_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata_o = rd_q.rdata;

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata_o)); // R4

    AST_POST_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_kind == REG_SET)) |=> (rdata_o == '0)); // R9

endmodule

// File: rtl/mbx_doorbell_unit.sv
module mbx_doorbell_unit
    import mbx_pkg::*;
#(
    parameter int                NUM_CORES = 4,
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 32,
    parameter logic [ADDR_W-1:0] ENA_BASE  = 'h00,
    parameter logic [ADDR_W-1:0] SET_BASE  = 'h40,
    parameter logic [ADDR_W-1:0] CLR_BASE  = 'h80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES-1:0]        bus_en,
    input  logic [NUM_CORES-1:0]        bus_wr,
    input  logic [NUM_CORES*ADDR_W-1:0] bus_addr,
    input  logic [NUM_CORES*DATA_W-1:0] bus_wdata,
    output logic [NUM_CORES*DATA_W-1:0] bus_rdata,
    output logic [NUM_CORES-1:0]        mbox_irq
);

    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    // Per-port decode results
    logic [NUM_CORES-1:0] set_sel [NUM_CORES];
    logic [NUM_CORES-1:0] clr_sel [NUM_CORES];
    logic [NUM_CORES-1:0] ena_sel [NUM_CORES];
    logic [NUM_CORES-1:0] rd_en;
    reg_kind_e            rd_kind [NUM_CORES];
    logic [CORE_W-1:0]    rd_core [NUM_CORES];

    // Per-core merged write controls
    logic [DATA_W-1:0]    set_mask_d [NUM_CORES];
    logic [DATA_W-1:0]    clr_mask_d [NUM_CORES];
    logic [NUM_CORES-1:0] ena_we_d;
    logic [NUM_CORES-1:0] ena_wbit_d;

    // Slot state seen by the read ports
    logic [NUM_CORES*DATA_W-1:0] mbox_flat_q;
    logic [NUM_CORES-1:0]        ena_vec_q;

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
        mbx_port_decode #(
            .NUM_CORES (NUM_CORES),
            .ADDR_W    (ADDR_W),
            .CORE_W    (CORE_W),
            .ENA_BASE  (ENA_BASE),
            .SET_BASE  (SET_BASE),
            .CLR_BASE  (CLR_BASE)
        ) u_dec (
            .bus_en   (bus_en[p]),
            .bus_wr   (bus_wr[p]),
            .bus_addr (bus_addr[p*ADDR_W +: ADDR_W]),
            .set_sel  (set_sel[p]),
            .clr_sel  (clr_sel[p]),
            .ena_sel  (ena_sel[p]),
            .rd_en    (rd_en[p]),
            .rd_kind  (rd_kind[p]),
            .rd_core  (rd_core[p])
        );

        mbx_read_port #(
            .NUM_CORES (NUM_CORES),
            .DATA_W    (DATA_W),
            .CORE_W    (CORE_W)
        ) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en    (rd_en[p]),
            .rd_kind  (rd_kind[p]),
            .rd_core  (rd_core[p]),
            .mbox_all (mbox_flat_q),
            .ena_all  (ena_vec_q),
            .rdata_o  (bus_rdata[p*DATA_W +: DATA_W])
        );
    end

    // Merge every port's writes per target core. Posts and acks OR together;
    // for enables the lowest port is applied last and so wins.
    always_comb begin
        for (int c = 0; c < NUM_CORES; c++) begin
            set_mask_d[c] = '0;
            clr_mask_d[c] = '0;
            ena_we_d[c]   = 1'b0;
            ena_wbit_d[c] = 1'b0;
        end
        for (int p = NUM_CORES - 1; p >= 0; p--) begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (set_sel[p][c]) begin
                    set_mask_d[c] = set_mask_d[c] | bus_wdata[p*DATA_W +: DATA_W];
                end
                if (clr_sel[p][c]) begin
                    clr_mask_d[c] = clr_mask_d[c] | bus_wdata[p*DATA_W +: DATA_W];
                end
                if (ena_sel[p][c]) begin
                    ena_we_d[c]   = 1'b1;
                    ena_wbit_d[c] = bus_wdata[p*DATA_W];
                end
            end
        end
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
        mbx_core_slot #(
            .DATA_W (DATA_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_mask (set_mask_d[c]),
            .clr_mask (clr_mask_d[c]),
            .ena_we   (ena_we_d[c]),
            .ena_wbit (ena_wbit_d[c]),
            .mbox_o   (mbox_flat_q[c*DATA_W +: DATA_W]),
            .ena_o    (ena_vec_q[c]),
            .irq_o    (mbox_irq[c])
        );
    end

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mbox_irq & ~ena_vec_q) == '0)); // R6

endmodule

// File: tb/mbx_doorbell_unit_tb.sv
`timescale 1ns/1ps
module mbx_doorbell_unit_tb;

    localparam int NC = 4;
    localparam int AW = 8;
    localparam int DW = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NC-1:0]     bus_en;
    logic [NC-1:0]     bus_wr;
    logic [NC*AW-1:0]  bus_addr;
    logic [NC*DW-1:0]  bus_wdata;
    logic [NC*DW-1:0]  bus_rdata;
    logic [NC-1:0]     mbox_irq;

    int n_checks = 0;
    int n_fail   = 0;

    logic [DW-1:0] exp_mb [NC];
    logic          exp_en [NC];

    always #2.5 clk = ~clk;

    mbx_doorbell_unit #(
        .NUM_CORES (NC),
        .ADDR_W    (AW),
        .DATA_W    (DW)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mbox_irq  (mbox_irq)
    );

    function automatic logic [AW-1:0] a_ena(int c); return AW'(8'h00 + 4*c);  endfunction
    function automatic logic [AW-1:0] a_set(int c); return AW'(8'h40 + 16*c); endfunction
    function automatic logic [AW-1:0] a_clr(int c); return AW'(8'h80 + 16*c); endfunction

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input int p, input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        bus_en[p]              = 1'b1;
        bus_wr[p]              = wr;
        bus_addr[p*AW +: AW]   = a;
        bus_wdata[p*DW +: DW]  = d;
    endtask

    task automatic step();
        @(negedge clk);
        bus_en = '0;
        bus_wr = '0;
    endtask

    task automatic wr(input int p, input logic [AW-1:0] a, input logic [DW-1:0] d);
        put(p, 1'b1, a, d);
        step();
    endtask

    task automatic rd(input int p, input logic [AW-1:0] a, output logic [DW-1:0] d);
        put(p, 1'b0, a, '0);
        step();
        d = bus_rdata[p*DW +: DW];
    endtask

    task automatic check_irqs(input string req);
        for (int c = 0; c < NC; c++) begin
            check(req, DW'(mbox_irq[c]), DW'(exp_en[c] && (exp_mb[c] != '0)));
        end
    endtask

    task automatic check_all_words(input string req);
        logic [DW-1:0] v;
        for (int c = 0; c < NC; c++) begin
            rd(c, a_clr(c), v);
            check(req, v, exp_mb[c]);
        end
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        bus_en = '0; bus_wr = '0; bus_addr = '0; bus_wdata = '0;
        for (int c = 0; c < NC; c++) begin exp_mb[c] = '0; exp_en[c] = 1'b0; end
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 irq", DW'(mbox_irq), '0);
        for (int p = 0; p < NC; p++) check("R1 rdata", bus_rdata[p*DW +: DW], '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: every register reads zero after reset
        for (int c = 0; c < NC; c++) begin
            rd(c, a_clr(c), v); check("R1 word", v, '0);
            rd(c, a_ena(c), v); check("R1 enable", v, '0);
        end

        // R5: only bit 0 of an enable write is kept
        for (int c = 0; c < NC; c++) begin
            wr((c + 1) % NC, a_ena(c), 32'hFFFF_FFFE);
            rd(c, a_ena(c), v); check("R5 upper bits ignored", v, '0);
            wr(c, a_ena(c), 32'h0000_0001);
            exp_en[c] = 1'b1;
            rd(c, a_ena(c), v); check("R5 enable bit", v, 32'h1);
        end

        // R2/R4/R6: post every bit of every word from rotating ports
        for (int t = 0; t < NC; t++) begin
            for (int b = 0; b < DW; b++) begin
                wr((t + b) % NC, a_set(t), DW'(1) << b);
                exp_mb[t] = exp_mb[t] | (DW'(1) << b);
                check_irqs("R6 after post");
                rd((t + 1) % NC, a_clr(t), v);
                check("R2 post accumulates", v, exp_mb[t]);
            end
            check_all_words("R2 other words untouched");
        end

        // R3/R6: acknowledge the lowest pending bit until empty
        for (int t = 0; t < NC; t++) begin
            for (int k = 0; k < DW; k++) begin
                wr(t, a_clr(t), DW'(1) << k);
                exp_mb[t] = exp_mb[t] & ~(DW'(1) << k);
                check_irqs("R6 after ack");
                rd(t, a_clr(t), v);
                check("R3 lowest bit ack", v, exp_mb[t]);
            end
            check("R6 drop after last ack", DW'(mbox_irq[t]), '0);
        end

        // R3: multi-bit acknowledge and zero acknowledge
        wr(1, a_set(0), 32'hA5A5_0F0F);
        wr(0, a_clr(0), 32'h0000_FFFF);
        exp_mb[0] = 32'hA5A5_0000;
        rd(0, a_clr(0), v); check("R3 multi-bit ack", v, exp_mb[0]);
        wr(0, a_clr(0), 32'h0);
        rd(0, a_clr(0), v); check("R3 zero ack", v, exp_mb[0]);

        // R6: enable gates the level
        wr(0, a_ena(0), 32'h0); exp_en[0] = 1'b0;
        check("R6 disabled", DW'(mbox_irq[0]), '0);
        wr(0, a_ena(0), 32'h1); exp_en[0] = 1'b1;
        check("R6 re-enabled", DW'(mbox_irq[0]), 32'h1);

        // R7: same-cycle post and acknowledge
        wr(1, a_set(2), 32'h1);
        exp_mb[2] = 32'h1;
        put(0, 1'b1, a_set(2), 32'h3);
        put(2, 1'b1, a_clr(2), 32'h3);
        step();
        exp_mb[2] = 32'h3;
        rd(2, a_clr(2), v); check("R7 clear then set", v, exp_mb[2]);
        put(1, 1'b1, a_set(2), 32'h4);
        put(3, 1'b1, a_clr(2), 32'h6);
        step();
        exp_mb[2] = 32'h5;
        rd(2, a_clr(2), v); check("R7 clear then set mixed", v, exp_mb[2]);
        check_irqs("R7 irq");

        // R8: concurrent posts OR together; enable conflict lowest port wins
        put(0, 1'b1, a_set(3), 32'h0000_0010);
        put(1, 1'b1, a_set(3), 32'h0000_0200);
        put(2, 1'b1, a_set(3), 32'h0000_0010);
        put(3, 1'b1, a_set(3), 32'h8000_0000);
        step();
        exp_mb[3] = 32'h8000_0210;
        rd(3, a_clr(3), v); check("R8 concurrent posts", v, exp_mb[3]);
        put(1, 1'b1, a_ena(3), 32'h0);
        put(2, 1'b1, a_ena(3), 32'h1);
        step();
        exp_en[3] = 1'b0;
        rd(3, a_ena(3), v); check("R8 enable priority", v, 32'h0);
        check_irqs("R8 irq");

        // R9: misaligned and unmapped writes change nothing
        wr(0, AW'(8'h44), 32'hFFFF_FFFF);
        wr(1, AW'(8'h88), 32'hFFFF_FFFF);
        wr(2, AW'(8'hC0), 32'hFFFF_FFFF);
        wr(3, AW'(8'h02), 32'h0);
        check_all_words("R9 words unchanged");
        rd(0, a_ena(0), v); check("R9 enable unchanged", v, 32'h1);
        rd(1, a_set(2), v); check("R9 post reg reads zero", v, '0);
        rd(2, AW'(8'hF0), v); check("R9 unmapped reads zero", v, '0);
        check_irqs("R9 irq");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule